// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Control

This block is the digital comparator of one synthesizer loop. It watches two synchronous edge streams, one from the reference path and one from the main divider, and drives two enables for an external charge pump. `up_o` makes the pump source current and `dn_o` makes it sink current. Whichever edge arrives first sets its own output. That output stays high until the other edge arrives. Both outputs then stay high together for a fixed number of clocks and are cleared at the same time. Because every comparison ends in this forced overlap, even a zero phase error produces a pulse of known width, and the detector has no dead zone.

A magnitude code sets the pump current as a multiple of a fixed unit. It passes to the pump through a register that only loads while no pulse is active. A power-down request is taken only when both enables are low, so a pulse that has started always finishes. While the block is powered down, both enables stay low and incoming edges are dropped. An edge that arrived during power-down does not start a pulse after release.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: A rising edge on `ref_in`, meaning high at a clock where the previous sample was low, sets `up_o` on that clock while the detector is idle and not powered down.
- R2: A rising edge on `div_in` under the same conditions sets `dn_o` on that clock.
- R3: Once one enable is high, it stays high until the other enable also rises. Both then stay high for exactly `RST_DLY` clocks and fall together. The leading enable is therefore high for the edge gap plus `RST_DLY` clocks.
- R4: Edges that arrive on the same clock raise both enables together for exactly `RST_DLY` clocks, the minimum pulse.
- R5: An edge that arrives while both enables are high is ignored. It neither lengthens the pulse nor starts a new one.
- R6: A power-down request (`pd_req` high) is accepted only on a clock where both enables are low. A pulse in progress completes, and `pd_o` rises on the clock after the first idle clock with the request present.
- R7: While `pd_o` is high, `up_o` and `dn_o` stay low and edges are ignored. An edge that arrives on the clock where the request is accepted is also ignored.
- R8: `pd_o` falls on the clock after `pd_req` is sampled low. An edge seen during power-down starts no pulse after release.
- R9: `mag_o` loads `mag_cfg` on each clock where both enables are low. During a pulse it holds its value.
- R10: After reset, `up_o`, `dn_o` and `pd_o` are 0 and `mag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference-path edge stream, synchronous to clk |
| div_in | input | 1 | Main-divider edge stream, synchronous to clk |
| pd_req | input | 1 | Power-down request, level |
| mag_cfg | input | MAG_W | Requested pump current multiple |
| up_o | output | 1 | Pump source enable |
| dn_o | output | 1 | Pump sink enable |
| mag_o | output | MAG_W | Current multiple applied to the pump |
| pd_o | output | 1 | Detector powered down |

## Verification
Two things can coincide in this block: a power-down request becoming acceptable, and a new edge arriving on the same idle clock. The bench raises `pd_req` and `ref_in` on the same clock. It expects `pd_o` to rise and `up_o` never to rise, then releases the request with the input still high and expects no pulse. It also raises the request while a pulse is active and expects the pulse to reach full width before power-down takes effect. A behavioural model compares all outputs on every clock.

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl #(
  parameter int RST_DLY = 3,
  parameter int MAG_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             div_in,
  input  logic             pd_req,
  input  logic [MAG_W-1:0] mag_cfg,
  output logic             up_o,
  output logic             dn_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             pd_o
);
  localparam int CNT_W = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_DLY - 1);

  logic             ref_q, div_q, up_q, dn_q, pd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAG_W-1:0] mag_q;

  logic ref_rise, div_rise, idle, both, go_pd, live;
  assign ref_rise = ref_in & ~ref_q;
  assign div_rise = div_in & ~div_q;
  assign idle     = ~up_q & ~dn_q;
  assign both     = up_q & dn_q;
  assign go_pd    = ~pd_q & idle & pd_req;
  assign live     = ~pd_q & ~go_pd & ~both;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      div_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      pd_q  <= 1'b0;
      cnt_q <= '0;
      mag_q <= '0;
    end else begin
      ref_q <= ref_in;
      div_q <= div_in;
      if (pd_q)       pd_q <= pd_req;
      else if (go_pd) pd_q <= 1'b1;
      if (both) begin
        if (cnt_q == LAST) begin
          up_q  <= 1'b0;
          dn_q  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (live) begin
        up_q <= up_q | ref_rise;
        dn_q <= dn_q | div_rise;
      end
      if (idle) mag_q <= mag_cfg;
    end
  end

  assign up_o  = up_q;
  assign dn_o  = dn_q;
  assign mag_o = mag_q;
  assign pd_o  = pd_q;
endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
module pfd_pump_ctrl_chk #(
  parameter int RST_DLY = 3,
  parameter int MAG_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_in,
  input logic             div_in,
  input logic             pd_req,
  input logic [MAG_W-1:0] mag_cfg,
  input logic             up_o,
  input logic             dn_o,
  input logic [MAG_W-1:0] mag_o,
  input logic             pd_o
);
  logic seen, ref_p, div_p;
  int   ovl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      ref_p <= 1'b0;
      div_p <= 1'b0;
      ovl   <= 0;
    end else begin
      seen  <= 1'b1;
      ref_p <= ref_in;
      div_p <= div_in;
      ovl   <= (up_o && dn_o) ? ovl + 1 : 0;
    end
  end

  a_r1_up_set: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ref_in && !ref_p && !up_o && !dn_o && !pd_o && !pd_req) |=> up_o);
  a_r2_dn_set: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && div_in && !div_p && !up_o && !dn_o && !pd_o && !pd_req) |=> dn_o);
  a_r3_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && !dn_o) |=> up_o);
  a_r3_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_o && !up_o) |=> dn_o);
  a_r3_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && dn_o) |=> ((up_o && dn_o) || (!up_o && !dn_o)));
  a_r4_overlap_max: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && dn_o) |-> (ovl < RST_DLY));
  a_r4_overlap_min: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && up_o && dn_o && ovl < RST_DLY - 1) |=> (up_o && dn_o));
  a_r6_pd_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !pd_o && (up_o || dn_o)) |=> !pd_o);
  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pd_o |-> (!up_o && !dn_o));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && !pd_req) |=> !pd_o);
  a_r9_mag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o || dn_o) |=> (mag_o == $past(mag_o)));
endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk #(.RST_DLY(RST_DLY), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in), .pd_req(pd_req),
  .mag_cfg(mag_cfg), .up_o(up_o), .dn_o(dn_o), .mag_o(mag_o), .pd_o(pd_o)
);

// File: tb/pfd_pump_ctrl_test.sv
module pfd_pump_ctrl_test;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, div_in = 1'b0, pd_req = 1'b0;
  logic [1:0] mag_cfg = 2'd0;
  logic up_o, dn_o, pd_o;
  logic [1:0] mag_o;

  int checks = 0, errors = 0;
  string tag = "R10";
  int up_cnt = 0, dn_cnt = 0;

  int m_up = 0, m_dn = 0, m_cnt = 0, m_pd = 0, m_mag = 0, p_ref = 0, p_div = 0;

  always #2 clk = ~clk;

  pfd_pump_ctrl #(.RST_DLY(DLY), .MAG_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in), .pd_req(pd_req),
    .mag_cfg(mag_cfg), .up_o(up_o), .dn_o(dn_o), .mag_o(mag_o), .pd_o(pd_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_up = 0; m_dn = 0; m_cnt = 0; m_pd = 0; m_mag = 0; p_ref = 0; p_div = 0;
    end else begin
      automatic int rr = (ref_in && !p_ref) ? 1 : 0;
      automatic int dr = (div_in && !p_div) ? 1 : 0;
      automatic int quiet = (m_up == 0 && m_dn == 0) ? 1 : 0;
      if (quiet != 0) m_mag = int'(mag_cfg);
      if (m_pd != 0) begin
        if (!pd_req) m_pd = 0;
      end else if (quiet != 0 && pd_req) begin
        m_pd = 1;
      end else if (m_up != 0 && m_dn != 0) begin
        m_cnt++;
        if (m_cnt == DLY) begin m_up = 0; m_dn = 0; m_cnt = 0; end
      end else begin
        if (rr != 0) m_up = 1;
        if (dr != 0) m_dn = 1;
      end
      p_ref = ref_in ? 1 : 0;
      p_div = div_in ? 1 : 0;
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag, "up_o", int'(up_o), m_up);
      chk(tag, "dn_o", int'(dn_o), m_dn);
      chk(tag, "pd_o", int'(pd_o), m_pd);
      chk(tag, "mag_o", int'(mag_o), m_mag);
      if (up_o) up_cnt++;
      if (dn_o) dn_cnt++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drop_all();
    ref_in = 1'b0; div_in = 1'b0;
    cyc(12);
  endtask

  task automatic pair(bit ref_first, int gap, int exp_lead);
    up_cnt = 0; dn_cnt = 0;
    if (gap == 0) begin
      ref_in = 1'b1; div_in = 1'b1;
    end else begin
      if (ref_first) ref_in = 1'b1; else div_in = 1'b1;
      cyc(gap);
      if (ref_first) div_in = 1'b1; else ref_in = 1'b1;
    end
    cyc(gap + DLY + 4);
    chk(tag, "lead width", ref_first ? up_cnt : dn_cnt, exp_lead);
    chk(tag, "lag width", ref_first ? dn_cnt : up_cnt, DLY);
    drop_all();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired (actual hung, expected finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    tag = "R10";
    chk("R10", "reset up", int'(up_o), 0);
    chk("R10", "reset dn", int'(dn_o), 0);
    chk("R10", "reset pd", int'(pd_o), 0);
    chk("R10", "reset mag", int'(mag_o), 0);
    cyc(2);

    tag = "R1"; pair(1'b1, 5, 5 + DLY);
    tag = "R2"; pair(1'b0, 4, 4 + DLY);
    tag = "R3"; pair(1'b1, 1, 1 + DLY);
    tag = "R3"; pair(1'b0, 9, 9 + DLY);
    tag = "R4"; pair(1'b1, 0, DLY);

    tag = "R5";
    up_cnt = 0; dn_cnt = 0;
    ref_in = 1'b1; cyc(2);
    div_in = 1'b1; cyc(1);
    ref_in = 1'b0; cyc(1);
    ref_in = 1'b1; cyc(10);
    chk("R5", "up width with overlap edge", up_cnt, 2 + DLY);
    chk("R5", "dn width with overlap edge", dn_cnt, DLY);
    drop_all();

    tag = "R9";
    mag_cfg = 2'd2; cyc(2);
    chk("R9", "mag idle load", int'(mag_o), 2);
    ref_in = 1'b1; cyc(2);
    mag_cfg = 2'd1; cyc(1);
    chk("R9", "mag held in pulse", int'(mag_o), 2);
    div_in = 1'b1; cyc(DLY + 3);
    chk("R9", "mag after pulse", int'(mag_o), 1);
    drop_all();

    tag = "R6";
    up_cnt = 0; dn_cnt = 0;
    ref_in = 1'b1; cyc(1);
    pd_req = 1'b1; cyc(3);
    chk("R6", "pd held off in pulse", int'(pd_o), 0);
    div_in = 1'b1; cyc(DLY + 4);
    chk("R6", "pulse completed width", up_cnt, 4 + DLY);
    chk("R6", "pd after pulse", int'(pd_o), 1);
    ref_in = 1'b0; div_in = 1'b0; cyc(2);

    tag = "R7";
    up_cnt = 0; dn_cnt = 0;
    ref_in = 1'b1; cyc(2); div_in = 1'b1; cyc(3);
    chk("R7", "no up in pd", up_cnt, 0);
    chk("R7", "no dn in pd", dn_cnt, 0);

    tag = "R8";
    pd_req = 1'b0; cyc(1);
    chk("R8", "pd released", int'(pd_o), 0);
    cyc(6);
    chk("R8", "no late pulse", up_cnt + dn_cnt, 0);
    drop_all();

    tag = "R7";
    up_cnt = 0;
    pd_req = 1'b1; ref_in = 1'b1; cyc(1);
    chk("R7", "same-cycle pd", int'(pd_o), 1);
    cyc(4);
    pd_req = 1'b0; cyc(6);
    chk("R7", "same-cycle edge dropped", up_cnt, 0);
    drop_all();

    tag = "R1"; pair(1'b1, 2, 2 + DLY);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule